// File: doc/BRIEF.md
# Text-Mode Character Display Controller

The block drives a 640x480, 60 Hz raster from a screen of character cells. The screen is 80 cells wide and 30 cells tall, and each cell is 8 pixels wide and 16 lines tall. A host writes cells into a screen memory of 128x32 words through a request/response port. Each word holds a character code and an attribute byte. The attribute byte selects the foreground and background colours, an intensify flag and a blink flag.

During the visible part of each line, the block reads the cell under the current pixel. It passes the character code and the line-within-cell to an external glyph lookup, and it receives that glyph row of 8 pixel bits one clock later. It turns each pixel bit and the attribute byte into 2-bit red, green and blue levels. The sync pulses are delayed by the same number of stages, so colour and sync always describe the same pixel.

The host port uses valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no read response is waiting, or when the waiting response is being taken in the same cycle. A read response stays on `rsp_valid`/`rsp_data` without change until `rsp_ready` is high. A write produces no response.

Top module: `txtvga_top`

## Requirements
- R1: `hsync_n` is low for exactly H_SYNC pixels in each line of H_TOT pixels. The pulse starts H_VIS+H_FP pixels after the first visible pixel. The defaults are 640 visible, 16 front porch, 96 sync, 48 back porch and 800 total.
- R2: `vsync_n` is low for exactly V_SYNC whole lines. It starts at line V_VIS+V_FP of a V_TOT-line frame, and it changes only together with the first pixel of a line. The defaults are 480 visible, 10 front porch, 2 sync, 33 back porch and 525 total.
- R3: The visible pixel (x, y) shows the cell at word address (y/16)*128 + x/8 on `req_addr`. Columns 80..127 and rows 30..31 are stored but never shown.
- R4: A read returns bits 15..0 of the last word written to that address, with bits 31..16 at zero. `rsp_valid` is high in the cycle after the request is accepted.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and `req_ready` is low.
- R6: The glyph port receives the code (cell bits 7..0) and the line within the cell (y mod 16). The pixel at x uses bit 7-(x mod 8) of the glyph row returned one clock later, so bit 7 is the leftmost pixel.
- R7: A visible pixel whose glyph bit is 1 and which is not hidden by blink shows the foreground colour. Red, green and blue are enabled by cell bits 10, 9 and 8. An enabled channel outputs 2'b10, or 2'b11 when bit 11 is set. A disabled channel outputs 0.
- R8: A visible pixel whose glyph bit is 0 shows the background colour. Red, green and blue are enabled by cell bits 14, 13 and 12, with level 2'b10 when enabled and 0 when not.
- R9: A blink phase starts visible after reset and toggles every BLINK_FRAMES frames (32 by default). In the hidden phase, every pixel of a cell with bit 15 set shows the background colour.
- R10: Outside the 640x480 visible area, all colour outputs are 0.
- R11: During reset, both syncs are high, all colour outputs are 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Host request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Screen word address, row*128+column |
| req_wdata | input | 32 | Write data; bits 31..16 are dropped |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 32 | Read data |
| glyph_code | output | 8 | Character code sent to the glyph lookup |
| glyph_row | output | GRW (4) | Line within the cell sent to the glyph lookup |
| glyph_bits | input | 8 | Glyph row, one clock after code/row |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The hardest state to reach from the ports is the hidden blink phase on a screen whose contents are known and stable. With the default geometry, that phase needs 32 full frames, which is far more than the run allows. The bench therefore instantiates a small raster with short porches, a 4x2 cell screen and a blink period of two frames. It locks its own pixel tracker to the first falling edge of vsync. It fills the screen with random words plus a few directed attribute patterns. Then it checks every pixel over several frames, so both blink phases appear under each content set.

// File: rtl/txv_pkg.sv
package txv_pkg;
  // Attribute byte bit positions (cell bits 15..8 mapped to 7..0)
  localparam int FG_BASE   = 0;
  localparam int INT_BIT   = 3;
  localparam int BG_BASE   = 4;
  localparam int BLINK_BIT = 7;
  localparam int PIX_PER_CELL = 8;
  localparam int NUM_CH = 3;

  typedef struct packed {
    logic [7:0] attr;
    logic [7:0] code;
  } cell_t;

  localparam logic [1:0] LVL_OFF    = 2'b00;
  localparam logic [1:0] LVL_NORMAL = 2'b10;
  localparam logic [1:0] LVL_BRIGHT = 2'b11;
endpackage

// File: rtl/txv_timing.sv
module txv_timing #(
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter int CELL_H = 16,
  parameter int MEM_COLS = 128,
  parameter int AW = 12,
  parameter int BLINK_FRAMES = 32,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT),
  localparam int GRW = $clog2(CELL_H),
  localparam int BW = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           vis_o,
  output logic           hs_o,
  output logic           vs_o,
  output logic [2:0]     px_o,
  output logic [GRW-1:0] grow_o,
  output logic [AW-1:0]  addr_o,
  output logic           blink_o
);
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic [BW-1:0] fcnt;
  logic          line_end, frame_end;

  assign line_end  = (hc == HW'(H_TOT - 1));
  assign frame_end = line_end && (vc == VW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= frame_end ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt    <= '0;
      blink_o <= 1'b0;
    end else if (frame_end) begin
      if (fcnt == BW'(BLINK_FRAMES - 1)) begin
        fcnt    <= '0;
        blink_o <= ~blink_o;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign vis_o  = (hc < HW'(H_VIS)) && (vc < VW'(V_VIS));
  assign hs_o   = (hc >= HW'(H_VIS + H_FP)) && (hc < HW'(H_VIS + H_FP + H_SYNC));
  assign vs_o   = (vc >= VW'(V_VIS + V_FP)) && (vc < VW'(V_VIS + V_FP + V_SYNC));
  assign px_o   = hc[2:0];
  assign grow_o = vc[GRW-1:0];
  assign addr_o = AW'(32'(vc >> GRW) * MEM_COLS + 32'(hc >> 3));

  // R2: the line counter only moves when the pixel counter restarts
  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vc != $past(vc)) |-> (hc == '0));

  // R9: blink phase only changes at the start of a frame
  assert_blink_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_o != $past(blink_o)) |-> (hc == '0 && vc == '0));
endmodule

// File: rtl/txv_screen_mem.sv
module txv_screen_mem import txv_pkg::*; #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_data,
  input  logic [AW-1:0] rd_addr,
  output cell_t         rd_cell
);
  cell_t mem [DEPTH];
  logic  take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (take && req_write) mem[req_addr] <= cell_t'(req_wdata[15:0]);
    rd_cell <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= {16'b0, mem[req_addr]};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R5: a stalled response is held unchanged
  assert_rsp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5: nothing new is taken while a response waits
  assert_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !take);
endmodule

// File: rtl/txv_colour.sv
module txv_colour import txv_pkg::*; (
  input  logic       vis,
  input  logic [7:0] attr,
  input  logic       pix,
  input  logic       blink_phase,
  output logic [1:0] lvl [NUM_CH]
);
  logic hidden, fg;

  assign hidden = attr[BLINK_BIT] && blink_phase;
  assign fg     = pix && !hidden;

  // lvl[0] blue, lvl[1] green, lvl[2] red
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_comb begin
      if (!vis)
        lvl[i] = LVL_OFF;
      else if (fg)
        lvl[i] = attr[FG_BASE+i] ? (attr[INT_BIT] ? LVL_BRIGHT : LVL_NORMAL) : LVL_OFF;
      else
        lvl[i] = attr[BG_BASE+i] ? LVL_NORMAL : LVL_OFF;
    end
  end
endmodule

// File: rtl/txtvga_top.sv
module txtvga_top import txv_pkg::*; #(
  parameter int COLS = 80,
  parameter int ROWS = 30,
  parameter int CELL_H = 16,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter int MEM_COLS = 128,
  parameter int MEM_ROWS = 32,
  parameter int BLINK_FRAMES = 32,
  localparam int AW = $clog2(MEM_COLS * MEM_ROWS),
  localparam int GRW = $clog2(CELL_H)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [31:0]    rsp_data,
  output logic [7:0]     glyph_code,
  output logic [GRW-1:0] glyph_row,
  input  logic [7:0]     glyph_bits,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic [1:0]     red,
  output logic [1:0]     green,
  output logic [1:0]     blue
);
  localparam int H_VIS = COLS * PIX_PER_CELL;
  localparam int V_VIS = ROWS * CELL_H;

  // stage 0: counters
  logic           vis0, hs0, vs0, blink_phase;
  logic [2:0]     px0;
  logic [GRW-1:0] grow0;
  logic [AW-1:0]  rd_addr;
  // stage 1: cell word available
  logic           vis1, hs1, vs1;
  logic [2:0]     px1;
  logic [GRW-1:0] grow1;
  cell_t          cell1;
  // stage 2: glyph row available
  logic           vis2, hs2, vs2;
  logic [2:0]     px2;
  logic [7:0]     attr2;
  logic           pix2;
  logic [1:0]     lvl [NUM_CH];

  txv_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CELL_H(CELL_H), .MEM_COLS(MEM_COLS), .AW(AW), .BLINK_FRAMES(BLINK_FRAMES)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .vis_o(vis0), .hs_o(hs0), .vs_o(vs0),
    .px_o(px0), .grow_o(grow0), .addr_o(rd_addr), .blink_o(blink_phase)
  );

  txv_screen_mem #(.DEPTH(MEM_COLS * MEM_ROWS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_addr(rd_addr), .rd_cell(cell1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {vis1, hs1, vs1, vis2, hs2, vs2} <= '0;
      px1 <= '0; grow1 <= '0; px2 <= '0; attr2 <= '0;
    end else begin
      vis1 <= vis0; hs1 <= hs0; vs1 <= vs0; px1 <= px0; grow1 <= grow0;
      vis2 <= vis1; hs2 <= hs1; vs2 <= vs1; px2 <= px1; attr2 <= cell1.attr;
    end
  end

  assign glyph_code = cell1.code;
  assign glyph_row  = grow1;
  assign pix2       = glyph_bits[3'd7 - px2];

  txv_colour u_colour (
    .vis(vis2), .attr(attr2), .pix(pix2), .blink_phase(blink_phase), .lvl(lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      red <= '0; green <= '0; blue <= '0;
    end else begin
      hsync_n <= ~hs2;
      vsync_n <= ~vs2;
      red   <= lvl[2];
      green <= lvl[1];
      blue  <= lvl[0];
    end
  end

  // checker state: length of the current low hsync pulse
  logic [15:0] hs_low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hs_low_cnt <= '0;
    else if (!hsync_n) hs_low_cnt <= hs_low_cnt + 1'b1;
    else hs_low_cnt <= '0;
  end

  // R1: every hsync pulse lasts exactly H_SYNC pixels
  assert_hsync_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> (hs_low_cnt == 16'(H_SYNC)));

  // R10: colour is dark whenever a sync pulse is active
  assert_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> (red == 2'b00 && green == 2'b00 && blue == 2'b00));
endmodule

// File: tb/sim_txtvga_top.sv
module sim_txtvga_top;
  localparam int COLS = 4, ROWS = 2, CH = 16;
  localparam int HFP = 3, HSY = 5, HBP = 4;
  localparam int VFP = 2, VSY = 3, VBP = 2;
  localparam int BL = 2;
  localparam int MCOLS = 128, MROWS = 32;
  localparam int AW = 12;
  localparam int H_VIS = COLS * 8, V_VIS = ROWS * CH;
  localparam int H_TOT = H_VIS + HFP + HSY + HBP;
  localparam int V_TOT = V_VIS + VFP + VSY + VBP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, hsync_n, vsync_n;
  logic [31:0] rsp_data;
  logic [7:0] glyph_code, glyph_bits;
  logic [3:0] glyph_row;
  logic [1:0] red, green, blue;

  always #5 clk = ~clk;

  txtvga_top #(
    .COLS(COLS), .ROWS(ROWS), .CELL_H(CH), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP), .MEM_COLS(MCOLS), .MEM_ROWS(MROWS),
    .BLINK_FRAMES(BL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .glyph_code(glyph_code), .glyph_row(glyph_row), .glyph_bits(glyph_bits),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
  );

  function automatic logic [7:0] gfun(input logic [7:0] c, input logic [3:0] r);
    return c ^ (8'(r) * 8'd29) ^ 8'h3C;
  endfunction

  // external glyph lookup model: one clock latency
  always @(posedge clk) glyph_bits <= gfun(glyph_code, glyph_row);

  int checks = 0, errors = 0;
  logic [15:0] shadow [MCOLS*MROWS];
  bit chk_en = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected colour (packed r,g,b) for a tracked position
  function automatic logic [5:0] exp_rgb(input int x, input int y, input int frame,
                                         output string tag);
    logic [15:0] w; logic [7:0] a, g; logic bitv, hid;
    logic [1:0] r, gr, b;
    if (x >= H_VIS || y >= V_VIS) begin tag = "R10"; return 6'b0; end
    w = shadow[(y / CH) * MCOLS + x / 8];
    a = w[15:8];
    g = gfun(w[7:0], 4'(y % CH));
    bitv = g[7 - (x % 8)];
    hid = a[7] && (((frame / BL) % 2) == 1);
    if (bitv && !hid) begin
      tag = "R7(R3,R6)";
      r  = a[2] ? {1'b1, a[3]} : 2'b00;
      gr = a[1] ? {1'b1, a[3]} : 2'b00;
      b  = a[0] ? {1'b1, a[3]} : 2'b00;
    end else begin
      tag = (bitv && hid) ? "R9" : "R8(R3,R6)";
      r  = a[6] ? 2'b10 : 2'b00;
      gr = a[5] ? 2'b10 : 2'b00;
      b  = a[4] ? 2'b10 : 2'b00;
    end
    return {r, gr, b};
  endfunction

  // pixel tracker locked to the first vsync falling edge
  bit synced = 0, prev_vs = 1;
  int bx = 0, by = 0, frame = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (synced) begin
        bx++;
        if (bx == H_TOT) begin
          bx = 0; by++;
          if (by == V_TOT) begin by = 0; frame++; end
        end
      end else if (prev_vs && !vsync_n) begin
        synced = 1; bx = 0; by = V_VIS + VFP; frame = 0;
      end
      prev_vs = vsync_n;
      if (synced) begin
        automatic bit hexp = (bx >= H_VIS + HFP) && (bx < H_VIS + HFP + HSY);
        automatic bit vexp = (by >= V_VIS + VFP) && (by < V_VIS + VFP + VSY);
        check(hsync_n == !hexp, "R1", hsync_n, !hexp);
        check(vsync_n == !vexp, "R2", vsync_n, !vexp);
        if (chk_en) begin
          automatic string tag;
          automatic logic [5:0] e = exp_rgb(bx, by, frame, tag);
          check({red, green, blue} == e, tag, {red, green, blue}, e);
        end
      end
    end
  end

  task automatic write_word(input int addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(addr); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    shadow[addr] = d[15:0];
  endtask

  task automatic read_check(input int addr);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(addr);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R4 latency", rsp_valid, 1);
    check(rsp_data == {16'b0, shadow[addr]}, "R4 data", rsp_data, {16'b0, shadow[addr]});
  endtask

  task automatic wait_blank_start();
    do @(posedge clk); while (!(synced && by == V_VIS && bx == 0));
  endtask

  task automatic fill_screen();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        write_word(r * MCOLS + c, $urandom());
  endtask

  task automatic run_frames(input int n);
    wait_blank_start();
    chk_en = 1;
    repeat (n * H_TOT * V_TOT) @(posedge clk);
    chk_en = 0;
  endtask

  initial begin
    void'($urandom(32'd2417));
    for (int i = 0; i < MCOLS * MROWS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check(hsync_n == 1'b1 && vsync_n == 1'b1, "R11 sync", {hsync_n, vsync_n}, 2'b11);
    check({red, green, blue} == 6'b0, "R11 rgb", {red, green, blue}, 0);
    check(rsp_valid == 1'b0, "R11 rsp", rsp_valid, 0);
    @(negedge clk); rst_n = 1;

    // round 1: random cells plus directed patterns
    fill_screen();
    write_word(0, 32'hFFFF_8F41);            // blink, bright white fg
    write_word(1, 32'h0000_7000);            // white bg only
    write_word(MCOLS + 3, 32'hA5A5_FFC3);    // every attribute bit
    write_word(COLS, 32'h0000_77FF);         // hidden column (R3)
    write_word(31 * MCOLS, 32'h0000_7F00);   // hidden row (R3)
    for (int i = 0; i < 12; i++) begin
      automatic int a = 200 + $urandom_range(0, 3000);
      write_word(a, $urandom());
      read_check(a);
    end
    read_check(0);
    read_check(MCOLS + 3);

    // R5: back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = AW'(MCOLS + 3);
    @(negedge clk);
    req_addr = AW'(0);
    for (int k = 0; k < 4; k++) begin
      check(rsp_valid == 1'b1, "R5 hold valid", rsp_valid, 1);
      check(req_ready == 1'b0, "R5 stall", req_ready, 0);
      check(rsp_data == {16'b0, shadow[MCOLS + 3]}, "R5 hold data", rsp_data, shadow[MCOLS + 3]);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1 && rsp_data == {16'b0, shadow[0]}, "R5 next", rsp_data, shadow[0]);
    @(negedge clk);

    run_frames(5);
    for (int rnd = 0; rnd < 2; rnd++) begin
      fill_screen();
      write_word($urandom_range(0, COLS - 1), 32'h0000_8000 | 32'($urandom_range(0, 32767)));
      run_frames(5);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule